// File: doc/BRIEF.md
# Segment-Size-Aware Page Hash Generator

This unit sits in the translation path of a hashed page-table walker. It takes a 64-bit effective address together with the segment descriptor that already matched it. From that pair it forms the virtual segment identifier, the page address inside the segment, the primary hash that indexes the hashed page table, and the compare tag that a table entry must carry to be a hit. It also resolves the protection key from the current privilege level and passes the no-execute flag through. Fetching table entries and comparing against them happen outside the block.

Two segment sizes are supported, 256 MB and 1 TB, and two page sizes, 4 KB and 16 MB. The segment size changes where the identifier sits in the descriptor, how many offset bits a segment spans, how the hash is formed and how wide the address slice in the tag is. In 1 TB segments the identifier is also folded into itself before it is mixed with the page index. The result can be registered, with one cycle of latency and a valid strobe, or it can be purely combinational.

Top module: `phg_hash_unit`

## Requirements
- R1: The identifier field is descriptor bits [61:12]. For a 256 MB segment `vsid_o` is that field (the descriptor shifted right by 12). For a 1 TB segment it is descriptor bits [61:24] (shifted right by 24), zero-extended to 50 bits. The segment size code is descriptor bits [63:62]: 01 means 1 TB, 00 means 256 MB.
- R2: A segment spans 28 offset bits (256 MB) or 40 (1 TB). The page-size bits are 24 (16 MB) when descriptor bit 8 is 1 and 12 (4 KB) otherwise. `page_addr_o` keeps the effective-address bits from the page-size bit up to the segment-size bit minus one, and clears all other bits.
- R3: For a 256 MB segment the hash is the identifier XOR the page index, where the page index is `page_addr_o` shifted right by the page-size bits.
- R4: For a 1 TB segment the hash is the identifier XOR (identifier shifted left by 25) XOR the page index. `hash_o` is the low HASH_W bits of the 64-bit result.
- R5: `tag_o` is descriptor bits [63:12] in place, with bits [11:0] zero, ORed with (`page_addr_o` shifted right by 16) ANDed with a mask covering bits 7 up to the segment-size bit minus one.
- R6: `key_o` is descriptor bit 10 when `user_i` is 1, and descriptor bit 11 otherwise.
- R7: `no_exec_o` equals descriptor bit 9.
- R8: Size codes 10 and 11 give the 256 MB geometry, identifier position and hash. The code bits still appear in `tag_o[63:62]`.
- R9: With REGISTERED=1, `out_valid_o` is 1 exactly in the cycle after a cycle with `in_valid_i` high, and the outputs then hold the results for that input. With REGISTERED=0, the outputs follow the inputs in the same cycle.
- R10: With REGISTERED=1, while reset is asserted and after it, until the first valid input, `out_valid_o` and every result output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Input address and descriptor are valid |
| ea_i | input | 64 | Effective address |
| desc_i | input | 64 | Matched segment descriptor |
| user_i | input | 1 | 1 = user (problem) state, 0 = supervisor |
| out_valid_o | output | 1 | Result outputs are valid |
| vsid_o | output | 50 | Virtual segment identifier |
| page_addr_o | output | 64 | Page address within the segment |
| hash_o | output | HASH_W | Primary page-table hash |
| tag_o | output | 64 | Page-table-entry compare tag |
| key_o | output | 1 | Selected protection key |
| no_exec_o | output | 1 | No-execute flag |

## Verification
The checker tests the valid timing and the key and no-execute selection against the inputs of the previous cycle on every clock. It also tests the geometry on every clock: the page address never has bits below 4 KB or above the segment size, and a 1 TB identifier never reaches past 38 bits. The exact hash values, the fold by 25 in 1 TB segments, the tag mask width and the handling of the reserved size codes depend on specific operand values. Only the bench's vectors show these, checked against values computed from the requirements: mixed segment and page sizes, all-ones and all-zero operands, reserved codes and back-to-back inputs.

// File: rtl/phg_pkg.sv
package phg_pkg;

    localparam int EA_W            = 64;
    localparam int DESC_W          = 64;
    localparam int VSID_W          = 50;
    localparam int VSID_LSB        = 12;
    localparam int VSID_MSB        = 61;
    localparam int SIZE_LSB        = 62;
    localparam int KEY_SUP_BIT     = 11;
    localparam int KEY_USR_BIT     = 10;
    localparam int NOEXEC_BIT      = 9;
    localparam int LARGE_BIT       = 8;
    localparam int HUGE_EXTRA_SHR  = 12;   // 24 - 12: identifier moves up in 1 TB mode
    localparam int SEG_BITS_SMALL  = 28;
    localparam int SEG_BITS_HUGE   = 40;
    localparam int PG_BITS_BASE    = 12;
    localparam int PG_BITS_LARGE   = 24;
    localparam int FOLD_SHL        = 25;
    localparam int TAG_SHR         = 16;
    localparam int TAG_FLOOR_BIT   = 7;
    localparam int DESC_HI_W       = DESC_W - VSID_LSB;
    localparam int PA_HI_W         = EA_W - TAG_SHR;

    typedef enum logic [1:0] {
        SEGSZ_256M = 2'b00,
        SEGSZ_1T   = 2'b01,
        SEGSZ_RSV2 = 2'b10,
        SEGSZ_RSV3 = 2'b11
    } seg_code_e;

    typedef struct packed {
        logic       huge_seg;
        logic [6:0] seg_bits;
        logic [6:0] page_bits;
    } geom_t;

    typedef struct packed {
        logic [VSID_W-1:0] vsid;
        logic [EA_W-1:0]   page_addr;
        logic [EA_W-1:0]   tag;
        logic              key;
        logic              no_exec;
    } result_t;

    // Mask with ones in [hi-1:lo]
    function automatic logic [EA_W-1:0] span_mask(input logic [6:0] hi, input logic [6:0] lo);
        return (EA_W'(1) << hi) - (EA_W'(1) << lo);
    endfunction

endpackage

// File: rtl/phg_geom_decode.sv
module phg_geom_decode
    import phg_pkg::*;
(
    input  logic [1:0]        size_code_i,
    input  logic              large_i,
    input  logic [VSID_W-1:0] vsid_field_i,
    output geom_t             geom_o,
    output logic [VSID_W-1:0] vsid_o
);
    seg_code_e code;
    assign code = seg_code_e'(size_code_i);

    always_comb begin
        geom_o.huge_seg  = (code == SEGSZ_1T);
        geom_o.seg_bits  = geom_o.huge_seg ? 7'(SEG_BITS_HUGE) : 7'(SEG_BITS_SMALL);
        geom_o.page_bits = large_i ? 7'(PG_BITS_LARGE) : 7'(PG_BITS_BASE);
        vsid_o = geom_o.huge_seg ? (vsid_field_i >> HUGE_EXTRA_SHR) : vsid_field_i;
    end
endmodule

// File: rtl/phg_hash_core.sv
module phg_hash_core
    import phg_pkg::*;
#(
    parameter int HASH_W = 39
) (
    input  logic [EA_W-1:0]   ea_i,
    input  geom_t             geom_i,
    input  logic [VSID_W-1:0] vsid_i,
    output logic [EA_W-1:0]   page_addr_o,
    output logic [HASH_W-1:0] hash_o
);
    logic [EA_W-1:0] seg_mask;
    logic [EA_W-1:0] page_index;
    logic [EA_W-1:0] vsid_wide;
    logic [EA_W-1:0] folded;
    logic [EA_W-1:0] full_hash;

    always_comb begin
        seg_mask    = span_mask(geom_i.seg_bits, geom_i.page_bits);
        page_addr_o = ea_i & seg_mask;
        page_index  = page_addr_o >> geom_i.page_bits;
        vsid_wide   = EA_W'(vsid_i);
        folded      = geom_i.huge_seg ? (vsid_wide << FOLD_SHL) : '0;
        full_hash   = vsid_wide ^ folded ^ page_index;
        hash_o      = full_hash[HASH_W-1:0];
    end
endmodule

// File: rtl/phg_tag_gen.sv
module phg_tag_gen
    import phg_pkg::*;
(
    input  logic [DESC_HI_W-1:0] desc_hi_i,
    input  logic [PA_HI_W-1:0]   pa_hi_i,
    input  logic [6:0]           seg_bits_i,
    output logic [EA_W-1:0]      tag_o
);
    logic [EA_W-1:0] pa_shifted;
    logic [EA_W-1:0] slice_mask;

    always_comb begin
        pa_shifted = EA_W'(pa_hi_i);
        slice_mask = span_mask(seg_bits_i, 7'(TAG_FLOOR_BIT));
        tag_o      = {desc_hi_i, {VSID_LSB{1'b0}}} | (pa_shifted & slice_mask);
    end
endmodule

// File: rtl/phg_hash_unit.sv
module phg_hash_unit
    import phg_pkg::*;
#(
    parameter int HASH_W     = 39,
    parameter bit REGISTERED = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid_i,
    input  logic [63:0]       ea_i,
    input  logic [63:0]       desc_i,
    input  logic              user_i,
    output logic              out_valid_o,
    output logic [49:0]       vsid_o,
    output logic [63:0]       page_addr_o,
    output logic [HASH_W-1:0] hash_o,
    output logic [63:0]       tag_o,
    output logic              key_o,
    output logic              no_exec_o
);
    geom_t             geom;
    logic [VSID_W-1:0] vsid_c;
    logic [EA_W-1:0]   page_addr_c;
    logic [HASH_W-1:0] hash_c;
    logic [EA_W-1:0]   tag_c;
    result_t           res_c;
    logic              unused_desc_low;

    assign unused_desc_low = ^desc_i[LARGE_BIT-1:0];

    phg_geom_decode u_geom (
        .size_code_i  (desc_i[SIZE_LSB +: 2]),
        .large_i      (desc_i[LARGE_BIT]),
        .vsid_field_i (desc_i[VSID_MSB:VSID_LSB]),
        .geom_o       (geom),
        .vsid_o       (vsid_c)
    );

    phg_hash_core #(.HASH_W(HASH_W)) u_hash (
        .ea_i        (ea_i),
        .geom_i      (geom),
        .vsid_i      (vsid_c),
        .page_addr_o (page_addr_c),
        .hash_o      (hash_c)
    );

    phg_tag_gen u_tag (
        .desc_hi_i  (desc_i[DESC_W-1:VSID_LSB]),
        .pa_hi_i    (page_addr_c[EA_W-1:TAG_SHR]),
        .seg_bits_i (geom.seg_bits),
        .tag_o      (tag_c)
    );

    always_comb begin
        res_c.vsid      = vsid_c;
        res_c.page_addr = page_addr_c;
        res_c.tag       = tag_c;
        res_c.key       = user_i ? desc_i[KEY_USR_BIT] : desc_i[KEY_SUP_BIT];
        res_c.no_exec   = desc_i[NOEXEC_BIT];
    end

    result_t           res_q;
    logic [HASH_W-1:0] hash_q;
    logic              valid_q;

    generate
        if (REGISTERED) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    valid_q <= 1'b0;
                    res_q   <= '0;
                    hash_q  <= '0;
                end else begin
                    valid_q <= in_valid_i;
                    if (in_valid_i) begin
                        res_q  <= res_c;
                        hash_q <= hash_c;
                    end
                end
            end
        end else begin : g_comb
            logic unused_clk_rst;
            assign unused_clk_rst = clk ^ rst;
            assign valid_q = in_valid_i;
            assign res_q   = res_c;
            assign hash_q  = hash_c;
        end
    endgenerate

    assign out_valid_o = valid_q;
    assign vsid_o      = res_q.vsid;
    assign page_addr_o = res_q.page_addr;
    assign hash_o      = hash_q;
    assign tag_o       = res_q.tag;
    assign key_o       = res_q.key;
    assign no_exec_o   = res_q.no_exec;
endmodule

// File: rtl/phg_checker.sv
module phg_checker #(
    parameter bit REGISTERED = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic        in_valid_i,
    input logic        user_i,
    input logic        ks_i,
    input logic        kp_i,
    input logic        nx_i,
    input logic        out_valid_o,
    input logic [49:0] vsid_o,
    input logic [63:0] page_addr_o,
    input logic [1:0]  tag_hi_o,
    input logic        key_o,
    input logic        no_exec_o
);
    // R2: no bits below the 4 KB page boundary
    assert_page_floor_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid_o |-> page_addr_o[11:0] == 12'h000);

    // R1 and R2: 1 TB geometry bounds
    assert_huge_bounds_R1: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && tag_hi_o == 2'b01) |-> (page_addr_o[63:40] == '0 && vsid_o[49:38] == '0));

    // R2 and R8: every other size code keeps the 256 MB span
    assert_small_bounds_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && tag_hi_o != 2'b01) |-> page_addr_o[63:28] == '0);

    generate
        if (REGISTERED) begin : g_reg
            assert_valid_follow_R9: assert property (@(posedge clk) disable iff (rst)
                in_valid_i |=> out_valid_o);
            assert_valid_drop_R9: assert property (@(posedge clk) disable iff (rst)
                !in_valid_i |=> !out_valid_o);
            assert_key_select_R6: assert property (@(posedge clk) disable iff (rst)
                out_valid_o |-> key_o == ($past(user_i) ? $past(kp_i) : $past(ks_i)));
            assert_noexec_copy_R7: assert property (@(posedge clk) disable iff (rst)
                out_valid_o |-> no_exec_o == $past(nx_i));
        end else begin : g_comb
            assert_valid_same_R9: assert property (@(posedge clk) disable iff (rst)
                out_valid_o == in_valid_i);
            assert_key_select_R6: assert property (@(posedge clk) disable iff (rst)
                out_valid_o |-> key_o == (user_i ? kp_i : ks_i));
            assert_noexec_copy_R7: assert property (@(posedge clk) disable iff (rst)
                out_valid_o |-> no_exec_o == nx_i);
        end
    endgenerate
endmodule

bind phg_hash_unit phg_checker #(.REGISTERED(REGISTERED)) u_phg_checker (
    .clk         (clk),
    .rst         (rst),
    .in_valid_i  (in_valid_i),
    .user_i      (user_i),
    .ks_i        (desc_i[11]),
    .kp_i        (desc_i[10]),
    .nx_i        (desc_i[9]),
    .out_valid_o (out_valid_o),
    .vsid_o      (vsid_o),
    .page_addr_o (page_addr_o),
    .tag_hi_o    (tag_o[63:62]),
    .key_o       (key_o),
    .no_exec_o   (no_exec_o)
);

// File: tb/phg_hash_unit_tb_top.sv
`timescale 1ns/1ps
module phg_hash_unit_tb_top;
    localparam int HW = 39;
    localparam int NV = 8;

    typedef struct packed {
        logic [63:0] ea;
        logic [1:0]  size;
        logic [49:0] vsid;
        logic        ks;
        logic        kp;
        logic        nx;
        logic        lg;
        logic        user;
        logic        exp_key;
        logic        exp_nx;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{64'h0000_0000_1234_5678, 2'b00, 50'h0_0ABC_DEF1_2345, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        '{64'hFFFF_FFFF_FFFF_FFFF, 2'b00, 50'h3_FFFF_FFFF_FFFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
        '{64'h0000_00AB_CDEF_0123, 2'b01, 50'h1_2345_6789_ABCD, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{64'hFFFF_FFFF_FFFF_FFFF, 2'b01, 50'h3_FFFF_FFFF_FFFF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
        '{64'h0000_0000_0F00_0000, 2'b00, 50'h0_0000_0000_0005, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        '{64'h0000_00AB_CDEF_0123, 2'b10, 50'h1_2345_6789_ABCD, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{64'hFFFF_FFFF_FFFF_FFFF, 2'b11, 50'h3_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
        '{64'h0000_0000_0000_0000, 2'b01, 50'h0_0000_0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [63:0]   ea = '0;
    logic [63:0]   desc = '0;
    logic          user = 1'b0;
    logic          out_valid;
    logic [49:0]   vsid;
    logic [63:0]   page_addr;
    logic [HW-1:0] hash;
    logic [63:0]   tag;
    logic          key;
    logic          no_exec;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    phg_hash_unit #(.HASH_W(HW), .REGISTERED(1'b1)) dut_i (
        .clk(clk), .rst(rst), .in_valid_i(in_valid), .ea_i(ea), .desc_i(desc),
        .user_i(user), .out_valid_o(out_valid), .vsid_o(vsid), .page_addr_o(page_addr),
        .hash_o(hash), .tag_o(tag), .key_o(key), .no_exec_o(no_exec)
    );

    function automatic logic [63:0] mk_desc(vec_t v);
        // R1: size [63:62], identifier [61:12]; R6: bit 11 supervisor, bit 10 user key;
        // R7: bit 9 no-execute; R2: bit 8 large page
        return {v.size, v.vsid, v.ks, v.kp, v.nx, v.lg, 8'h00};
    endfunction

    task automatic check(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic check_vec(input vec_t v, input logic [63:0] d);
        logic        huge;
        int          sb;
        int          pb;
        logic [63:0] ev;
        logic [63:0] epa;
        logic [63:0] eh;
        logic [63:0] et;
        string       rq_id;
        string       rq_h;
        huge  = (v.size == 2'b01);
        sb    = huge ? 40 : 28;
        pb    = v.lg ? 24 : 12;
        ev    = huge ? ((d & 64'h3FFF_FFFF_FFFF_F000) >> 24) : ((d & 64'h3FFF_FFFF_FFFF_F000) >> 12);
        epa   = v.ea & ((64'd1 << sb) - (64'd1 << pb));
        eh    = ev ^ (huge ? (ev << 25) : 64'd0) ^ (epa >> pb);
        eh    = eh & ((64'd1 << HW) - 64'd1);
        et    = (d & 64'hFFFF_FFFF_FFFF_F000) | ((epa >> 16) & ((64'd1 << sb) - 64'h80));
        rq_id = (v.size[1]) ? "R8" : "R1";
        rq_h  = (v.size[1]) ? "R8" : (huge ? "R4" : "R3");
        check("R9", "out_valid", 64'(out_valid), 64'd1);
        check(rq_id, "vsid", 64'(vsid), ev);
        check("R2", "page_addr", page_addr, epa);
        check(rq_h, "hash", 64'(hash), eh);
        check("R5", "tag", tag, et);
        check("R6", "key", 64'(key), 64'(v.exp_key));
        check("R7", "no_exec", 64'(no_exec), 64'(v.exp_nx));
    endtask

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", "out_valid in reset", 64'(out_valid), 64'd0);
        check("R10", "hash in reset", 64'(hash), 64'd0);
        check("R10", "tag in reset", tag, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R10", "out_valid after reset", 64'(out_valid), 64'd0);
        check("R10", "vsid after reset", 64'(vsid), 64'd0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            desc     = mk_desc(VECS[i]);
            ea       = VECS[i].ea;
            user     = VECS[i].user;
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            check_vec(VECS[i], mk_desc(VECS[i]));
            @(negedge clk);
            // R9: valid drops the cycle after an idle input
            check("R9", "out_valid after idle", 64'(out_valid), 64'd0);
        end

        // R9: back-to-back inputs, each result one cycle later
        desc = mk_desc(VECS[2]); ea = VECS[2].ea; user = VECS[2].user; in_valid = 1'b1;
        @(negedge clk);
        check_vec(VECS[2], mk_desc(VECS[2]));
        desc = mk_desc(VECS[4]); ea = VECS[4].ea; user = VECS[4].user;
        @(negedge clk);
        in_valid = 1'b0;
        check_vec(VECS[4], mk_desc(VECS[4]));
        // R9: outputs hold the last result while idle
        desc = mk_desc(VECS[1]); ea = VECS[1].ea; user = VECS[1].user;
        @(negedge clk);
        check("R9", "tag held while idle", tag,
              (mk_desc(VECS[4]) & 64'hFFFF_FFFF_FFFF_F000) | 64'h0000_0000_0000_0F00);

        // R10: reset mid-stream clears the outputs
        rst = 1'b1;
        @(negedge clk);
        check("R10", "out_valid on re-reset", 64'(out_valid), 64'd0);
        check("R10", "page_addr on re-reset", page_addr, 64'd0);
        rst = 1'b0;
        @(negedge clk);

        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule